// File: doc/BRIEF.md
# Serial Pattern Generator Channel

This block drives one serial clock line and one data line. It plays a seed pattern of up to 64 bits, least significant bit first, and repeats the pattern a programmed number of times. When every pass has been sent it pulses a completion strobe for one cycle. The serial clock comes from the I/O clock through a programmable divider. A polarity bit chooses whether the data line moves on the rising or on the falling edge of the serial clock.

The configuration is taken from the inputs while the channel is disabled. It is frozen on the cycle in which the enable is first seen high, so a change to the inputs during a run does not disturb the pattern in flight. Dropping the enable stops the channel at once. After a run finishes, the channel waits idle until the enable is taken low and raised again.

Top module: `serpat_channel`

## Requirements
- R1: After reset, `sclk_o` and `sdat_o` are 0 and `done_o` is 0.
- R2: While running, every level of `sclk_o` lasts `ratio_i + 1` I/O clock cycles. The ratio is taken as captured at the start.
- R3: When idle or finished, `sclk_o` rests at the captured polarity value and `sdat_o` is 0. With polarity 1, the first clock edge of a run is falling and data moves on rising edges. With polarity 0, the first edge is rising and data moves on falling edges.
- R4: Bit 0 of the seed is presented first, followed by ascending bits. After bit number `len_i`, the index returns to bit 0. A `len_i` of 0 sends 1 bit per pass and 63 sends 64 bits.
- R5: The pattern is sent `reps_i + 1` times. A value of 0 gives one pass and 1023 gives 1024 passes.
- R6: `done_o` is high for exactly one cycle. That cycle lies 2·(ratio+1)·(len+1)·(reps+1) cycles after the first running cycle. `done_o` is 0 during the run.
- R7: Changes on `pol_i`, `ratio_i`, `seed_lo_i`, `seed_hi_i`, `len_i` or `reps_i` while `en_i` is high have no effect. The values used are those present in the cycle where `en_i` is first seen high.
- R8: If `en_i` is 0 in a cycle, the next cycle shows an idle line with `sdat_o` 0 and `done_o` 0. A later enable starts again from seed bit 0 and the first pass.
- R9: After completion with `en_i` still high, the outputs stay idle and no further `done_o` pulse occurs.
- R10: `seed_lo_i` supplies seed bits 0 to 31 and `seed_hi_i` supplies seed bits 32 to 63.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | I/O clock |
| rst | input | 1 | Synchronous active-high reset |
| en_i | input | 1 | Channel enable; a rising level starts a run |
| pol_i | input | 1 | Edge select for data changes (1 = rising) |
| ratio_i | input | 32 | Half-period length of the serial clock, minus one |
| seed_lo_i | input | 32 | Seed bits 31..0 |
| seed_hi_i | input | 32 | Seed bits 63..32 |
| len_i | input | 6 | Pattern length minus one |
| reps_i | input | 10 | Pass count minus one |
| sclk_o | output | 1 | Serial clock |
| sdat_o | output | 1 | Serial data |
| done_o | output | 1 | One-cycle completion strobe |

## Verification
The bench builds the block with the package defaults: a 64-bit seed, a 6-bit length field, a 10-bit pass count and a 32-bit divider. With these values the full 64-bit pattern can be reached, which exercises the boundary between the two seed words. The largest pass count of 1024 can also be reached, because the pass count is run with a one-bit pattern at ratio 0. Ratios are kept small, so every waveform can be compared cycle by cycle against a closed-form model within the cycle budget.

// File: rtl/serpat_pkg.sv
package serpat_pkg;

    parameter int unsigned SEED_W = 64;
    parameter int unsigned WORD_W = SEED_W / 2;
    parameter int unsigned LEN_W  = $clog2(SEED_W);
    parameter int unsigned REP_W  = 10;
    parameter int unsigned DIV_W  = 32;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_RUN  = 2'd1,
        ST_FIN  = 2'd2
    } state_e;

    typedef struct packed {
        logic              pol;
        logic [DIV_W-1:0]  ratio;
        logic [SEED_W-1:0] seed;
        logic [LEN_W-1:0]  len;
        logic [REP_W-1:0]  reps;
    } cfg_t;

    // Resting level of the serial clock for a given polarity
    function automatic logic rest_level(input logic pol);
        return pol;
    endfunction

    function automatic logic pick_bit(input logic [SEED_W-1:0] seed,
                                      input logic [LEN_W-1:0]  idx);
        return seed[idx];
    endfunction

endpackage

// File: rtl/serpat_cfg_latch.sv
module serpat_cfg_latch
    import serpat_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic load,
    input  cfg_t cfg_d,
    output cfg_t cfg_q
);
    always_ff @(posedge clk) begin
        if (rst) begin
            cfg_q <= '0;
        end else if (load) begin
            cfg_q <= cfg_d;
        end
    end
endmodule

// File: rtl/serpat_divider.sv
module serpat_divider
    import serpat_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             run,
    input  logic [DIV_W-1:0] ratio,
    output logic             tick,
    output logic             phase
);
    logic [DIV_W-1:0] cnt_q;

    assign tick = run && (cnt_q == ratio);

    always_ff @(posedge clk) begin
        if (rst || !run) begin
            cnt_q <= '0;
            phase <= 1'b0;
        end else if (cnt_q == ratio) begin
            cnt_q <= '0;
            phase <= ~phase;
        end else begin
            cnt_q <= cnt_q + DIV_W'(1);
        end
    end
endmodule

// File: rtl/serpat_sequencer.sv
module serpat_sequencer
    import serpat_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             en,
    input  logic             tick,
    input  logic             phase,
    input  logic [LEN_W-1:0] len,
    input  logic [REP_W-1:0] reps,
    output state_e           state,
    output logic [LEN_W-1:0] bit_idx,
    output logic [REP_W-1:0] rep_idx,
    output logic             done
);
    always_ff @(posedge clk) begin
        if (rst) begin
            state   <= ST_IDLE;
            bit_idx <= '0;
            rep_idx <= '0;
            done    <= 1'b0;
        end else begin
            done <= 1'b0;
            if (!en) begin
                state   <= ST_IDLE;
                bit_idx <= '0;
                rep_idx <= '0;
            end else begin
                unique case (state)
                    ST_IDLE: begin
                        state   <= ST_RUN;
                        bit_idx <= '0;
                        rep_idx <= '0;
                    end
                    ST_RUN: begin
                        // Second half of a bit ends: advance on the change edge
                        if (tick && phase) begin
                            if (bit_idx == len) begin
                                bit_idx <= '0;
                                if (rep_idx == reps) begin
                                    rep_idx <= '0;
                                    state   <= ST_FIN;
                                    done    <= 1'b1;
                                end else begin
                                    rep_idx <= rep_idx + REP_W'(1);
                                end
                            end else begin
                                bit_idx <= bit_idx + LEN_W'(1);
                            end
                        end
                    end
                    default: state <= ST_FIN;
                endcase
            end
        end
    end
endmodule

// File: rtl/serpat_channel.sv
module serpat_channel
    import serpat_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              en_i,
    input  logic              pol_i,
    input  logic [DIV_W-1:0]  ratio_i,
    input  logic [WORD_W-1:0] seed_lo_i,
    input  logic [WORD_W-1:0] seed_hi_i,
    input  logic [LEN_W-1:0]  len_i,
    input  logic [REP_W-1:0]  reps_i,
    output logic              sclk_o,
    output logic              sdat_o,
    output logic              done_o
);
    cfg_t             cfg_d;
    cfg_t             cfg_q;
    state_e           state_q;
    logic [LEN_W-1:0] bit_idx;
    logic [REP_W-1:0] rep_idx;
    logic             tick;
    logic             phase;
    logic             running;

    assign cfg_d.pol   = pol_i;
    assign cfg_d.ratio = ratio_i;
    assign cfg_d.seed  = {seed_hi_i, seed_lo_i};
    assign cfg_d.len   = len_i;
    assign cfg_d.reps  = reps_i;

    assign running = (state_q == ST_RUN);

    serpat_cfg_latch u_cfg (
        .clk   (clk),
        .rst   (rst),
        .load  (state_q == ST_IDLE),
        .cfg_d (cfg_d),
        .cfg_q (cfg_q)
    );

    serpat_divider u_div (
        .clk   (clk),
        .rst   (rst),
        .run   (running),
        .ratio (cfg_q.ratio),
        .tick  (tick),
        .phase (phase)
    );

    serpat_sequencer u_seq (
        .clk     (clk),
        .rst     (rst),
        .en      (en_i),
        .tick    (tick),
        .phase   (phase),
        .len     (cfg_q.len),
        .reps    (cfg_q.reps),
        .state   (state_q),
        .bit_idx (bit_idx),
        .rep_idx (rep_idx),
        .done    (done_o)
    );

    always_comb begin
        if (running) begin
            sclk_o = rest_level(cfg_q.pol) ^ phase;
            sdat_o = pick_bit(cfg_q.seed, bit_idx);
        end else begin
            sclk_o = rest_level(cfg_q.pol);
            sdat_o = 1'b0;
        end
    end
endmodule

// File: rtl/serpat_checker.sv
module serpat_checker
    import serpat_pkg::*;
(
    input logic             clk,
    input logic             rst,
    input logic             en_i,
    input logic             sclk_o,
    input logic             sdat_o,
    input logic             done_o,
    input state_e           state,
    input cfg_t             cfg,
    input logic [LEN_W-1:0] bit_idx,
    input logic [REP_W-1:0] rep_idx
);
    // R6: the completion strobe never lasts two cycles
    a_r6_done_single: assert property (@(posedge clk) disable iff (rst)
        done_o |=> !done_o);

    // R8: a low enable leaves a quiet line one cycle later
    a_r8_abort_idle: assert property (@(posedge clk) disable iff (rst)
        !en_i |=> (!sdat_o && !done_o));

    // R3: data moves only on the edge that returns the clock to its rest level
    a_r3_change_edge: assert property (@(posedge clk) disable iff (rst)
        (state == ST_RUN && $past(state) == ST_RUN && sdat_o != $past(sdat_o))
        |-> (sclk_o == cfg.pol && $past(sclk_o) != cfg.pol));

    // R7: captured configuration holds while the channel is active
    a_r7_cfg_locked: assert property (@(posedge clk) disable iff (rst)
        (state != ST_IDLE && $past(state) != ST_IDLE) |-> cfg == $past(cfg));

    // R4: bit index stays within the captured length
    a_r4_bit_bound: assert property (@(posedge clk) disable iff (rst)
        state == ST_RUN |-> bit_idx <= cfg.len);

    // R5: pass index stays within the captured pass count
    a_r5_rep_bound: assert property (@(posedge clk) disable iff (rst)
        state == ST_RUN |-> rep_idx <= cfg.reps);

    // R9: a finished channel stays silent
    a_r9_fin_quiet: assert property (@(posedge clk) disable iff (rst)
        (state == ST_FIN && $past(state) == ST_FIN) |-> (!done_o && !sdat_o));
endmodule

bind serpat_channel serpat_checker u_chk (
    .clk     (clk),
    .rst     (rst),
    .en_i    (en_i),
    .sclk_o  (sclk_o),
    .sdat_o  (sdat_o),
    .done_o  (done_o),
    .state   (state_q),
    .cfg     (cfg_q),
    .bit_idx (bit_idx),
    .rep_idx (rep_idx)
);

// File: tb/serpat_channel_tb.sv
`timescale 1ns/1ps
module serpat_channel_tb;
    import serpat_pkg::*;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              en_i = 1'b0;
    logic              pol_i = 1'b0;
    logic [DIV_W-1:0]  ratio_i = '0;
    logic [WORD_W-1:0] seed_lo_i = '0;
    logic [WORD_W-1:0] seed_hi_i = '0;
    logic [LEN_W-1:0]  len_i = '0;
    logic [REP_W-1:0]  reps_i = '0;
    logic              sclk_o, sdat_o, done_o;

    int unsigned n_checks = 0;
    int unsigned n_errors = 0;

    always #2.5 clk = ~clk;

    serpat_channel u_dut (
        .clk(clk), .rst(rst), .en_i(en_i), .pol_i(pol_i), .ratio_i(ratio_i),
        .seed_lo_i(seed_lo_i), .seed_hi_i(seed_hi_i), .len_i(len_i),
        .reps_i(reps_i), .sclk_o(sclk_o), .sdat_o(sdat_o), .done_o(done_o)
    );

    task automatic chk(input logic ok, input string tag,
                       input longint unsigned act, input longint unsigned exp);
        n_checks++;
        if (!ok) begin
            n_errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic logic exp_clk(input logic pol, input longint unsigned r,
                                     input longint unsigned k);
        return pol ^ logic'((k / (r + 1)) % 2);
    endfunction

    function automatic logic exp_dat(input logic [SEED_W-1:0] seed,
                                     input longint unsigned n,
                                     input longint unsigned r,
                                     input longint unsigned k);
        return seed[(k / (2 * (r + 1))) % n];
    endfunction

    task automatic apply(input logic pol, input longint unsigned r,
                         input logic [SEED_W-1:0] seed,
                         input int unsigned len, input int unsigned reps);
        pol_i     = pol;
        ratio_i   = DIV_W'(r);
        seed_lo_i = seed[WORD_W-1:0];
        seed_hi_i = seed[SEED_W-1:WORD_W];
        len_i     = LEN_W'(len);
        reps_i    = REP_W'(reps);
    endtask

    // Full run; stop_at > 0 aborts after that many compared cycles
    task automatic run_case(input string tag, input logic pol,
                            input longint unsigned r,
                            input logic [SEED_W-1:0] seed,
                            input int unsigned len, input int unsigned reps,
                            input bit scramble, input longint unsigned stop_at);
        longint unsigned total;
        longint unsigned last;
        int unsigned bad;
        logic ac, ad, ec, ed;
        total = 2 * (r + 1) * (len + 1) * (reps + 1);
        last  = (stop_at != 0) ? stop_at : total;
        bad   = 0;
        @(negedge clk);
        apply(pol, r, seed, len, reps);
        en_i = 1'b0;
        @(negedge clk);
        @(negedge clk);
        chk(sclk_o == pol && !sdat_o, {tag, " R3 rest level before run"},
            {sclk_o, sdat_o}, {pol, 1'b0});
        en_i = 1'b1;
        for (longint unsigned k = 0; k < last; k++) begin
            @(negedge clk);
            ec = exp_clk(pol, r, k);
            ed = exp_dat(seed, len + 1, r, k);
            ac = sclk_o;
            ad = sdat_o;
            if ((ac !== ec || ad !== ed || done_o !== 1'b0) && bad == 0)
                $display("FAIL %s R2/R4/R6 waveform at k=%0d actual=%b%b%b expected=%b%b0",
                         tag, k, ac, ad, done_o, ec, ed);
            if (ac !== ec || ad !== ed || done_o !== 1'b0) bad++;
            if (scramble)
                apply(1'($urandom), longint'($urandom_range(5)),
                      {$urandom, $urandom}, $urandom_range(63), $urandom_range(3));
        end
        n_checks++;
        if (bad != 0) n_errors++;
        if (stop_at != 0) begin
            en_i = 1'b0;
            @(negedge clk);
            chk(!sdat_o && !done_o && sclk_o == pol, {tag, " R8 abort idles line"},
                {sclk_o, sdat_o, done_o}, {pol, 2'b00});
            return;
        end
        @(negedge clk);
        chk(done_o && !sdat_o && sclk_o == pol, {tag, " R6 done at end"},
            {sclk_o, sdat_o, done_o}, {pol, 2'b01});
        for (int i = 0; i < 12; i++) begin
            @(negedge clk);
            if (done_o || sdat_o || sclk_o != pol) bad++;
        end
        chk(bad == 0, {tag, " R9 idle after finish"}, bad, 0);
        en_i = 1'b0;
    endtask

    initial begin
        #(5.0 * 200000);
        n_errors++;
        $display("FAIL watchdog expired actual=timeout expected=finish");
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks + 1);
        $finish;
    end

    initial begin
        void'($urandom(32'd4721));
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk(!sclk_o && !sdat_o && !done_o, "R1 reset state",
            {sclk_o, sdat_o, done_o}, 0);

        // R4 one-bit pattern, R3 both polarities
        run_case("len1_pol0", 1'b0, 0, 64'h1, 0, 2, 1'b0, 0);
        run_case("len1_pol1", 1'b1, 2, 64'h0, 0, 1, 1'b0, 0);
        // R10 full 64-bit pattern across both words
        run_case("R10 words", 1'b0, 1, 64'hF0F0_0001_8000_A5C3, 63, 1, 1'b0, 0);
        // R5 maximum pass count
        run_case("R5 max reps", 1'b1, 0, 64'h1, 0, 1023, 1'b0, 0);
        // R2 larger divider
        run_case("R2 ratio9", 1'b0, 9, 64'h2D, 7, 0, 1'b0, 0);
        // R7 inputs churn during the run
        run_case("R7 scramble", 1'b1, 2, 64'hDEAD_BEEF_1234_5678, 40, 2, 1'b1, 0);
        // R8 abort then restart from bit 0
        run_case("R8 abort", 1'b0, 1, 64'h6, 5, 3, 1'b0, 17);
        run_case("R8 restart", 1'b0, 1, 64'h6, 5, 1, 1'b0, 0);

        for (int t = 0; t < 10; t++) begin
            run_case("random", 1'($urandom), longint'($urandom_range(3)),
                     {$urandom, $urandom}, $urandom_range(63), $urandom_range(3),
                     1'b0, 0);
        end

        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end
endmodule